// File: doc/BRIEF.md
# Multi-format compare and condition unit

This block takes two 32-bit operands and decides how they relate to each other: equal, less, greater or unordered. The operands are read as signed integers, unsigned integers or single-precision floating-point values, and a mode input picks which. The relationship leaves the block in two forms. One is a combinational 2-bit relation code. The other is a 4-bit NZCV flag set, which is written into a flag register on any cycle where the compare strobe is high. Both forms are the same for every operand type.

A second, independent path reads a 4-bit condition selector and tests it against the registered flags. It returns a pass/fail gate that a following conditional operation can use. Only eight selector values have a meaning. Any other value gives a failing gate and raises an error output. Because the gate reads the registered flags, a compare strobed in one cycle drives the gate in the next. The compare input has no back-pressure: the strobe is taken on every cycle it is high, so the block never stalls its source.

Top module: `cmpu_top`

## Requirements
- R1: `rel_code` is combinational from the current operands and mode: 2'b00 equal, 2'b01 A less than B, 2'b10 A greater than B, 2'b11 unordered.
- R2: With `cmp_mode` = 2'b00 the operands are ordered as two's-complement signed integers.
- R3: With `cmp_mode` = 2'b01 the operands are ordered as unsigned integers.
- R4: With `cmp_mode[1]` = 1 the operands are single-precision floats (bit 31 sign, bits 30:23 exponent, bits 22:0 fraction). When both are positive, a larger magnitude is greater. When both are negative, a larger magnitude is less. When the signs differ, the negative operand is less. Infinities order like any other value.
- R5: In float mode, +0 and -0 compare as equal in all four sign combinations.
- R6: In float mode the result is unordered when either operand is a NaN, that is, an all-ones exponent with a nonzero fraction. Integer modes never give unordered.
- R7: On a rising clock edge with `cmp_valid` high, `flags` (bit 3 N, bit 2 Z, bit 1 C, bit 0 V) loads 4'b0100 for equal, 4'b1000 for less, 4'b1001 for greater and 4'b0000 for unordered. The new value appears after that edge.
- R8: `flags` resets to 4'b0000 and keeps its value on every edge where `cmp_valid` is low.
- R9: `cond_pass` is combinational from `cond_sel` and `flags`. The selectors are: 4'b0000 Z set; 4'b0001 Z clear; 4'b1010 N equals V; 4'b1011 N differs from V; 4'b1100 Z clear and N equals V; 4'b1101 Z set or N differs from V; 4'b1110 always 1; 4'b1111 always 0. With the unordered flags, both 4'b1010 and 4'b1100 pass.
- R10: Any other `cond_sel` value (4'b0010 through 4'b1001) gives `cond_pass` = 0 and `cond_err` = 1. `cond_err` is 0 for the eight selectors listed in R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Compare strobe; loads the flag register |
| cmp_mode | input | 2 | 00 signed, 01 unsigned, 1x float |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| rel_code | output | 2 | Relation of A to B (combinational) |
| flags | output | 4 | Registered NZCV flags |
| cond_sel | input | 4 | Condition selector |
| cond_pass | output | 1 | Condition gate from the registered flags |
| cond_err | output | 1 | Selector has no defined meaning |

## Verification
A wrong ordering decision inside one of the order units shows at `rel_code` in the same cycle the operands are applied. It shows at `flags` one edge after the strobe. A corrupted flag register gives a flag value outside the four legal patterns, or a flag change on a cycle with no strobe. Either is visible on `flags` right after the offending edge. The gates for all sixteen selectors are then compared against the flags in the same cycle. A decoder fault therefore appears within a cycle of the compare that exposes it.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;

  typedef enum logic [1:0] {
    REL_EQ = 2'b00,
    REL_LT = 2'b01,
    REL_GT = 2'b10,
    REL_UN = 2'b11
  } rel_e;

  typedef enum logic [3:0] {
    CS_ZSET  = 4'b0000,
    CS_ZCLR  = 4'b0001,
    CS_GEQ   = 4'b1010,
    CS_LESS  = 4'b1011,
    CS_GRT   = 4'b1100,
    CS_LEQ   = 4'b1101,
    CS_ALW   = 4'b1110,
    CS_NEVER = 4'b1111
  } csel_e;

  localparam logic [1:0] MODE_SINT = 2'b00;
  localparam logic [1:0] MODE_UINT = 2'b01;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  function automatic logic [3:0] rel_to_nzcv(input rel_e r);
    logic [3:0] f;
    f = 4'b0000;
    case (r)
      REL_EQ: f[FLAG_Z] = 1'b1;
      REL_LT: f[FLAG_N] = 1'b1;
      REL_GT: begin
        f[FLAG_N] = 1'b1;
        f[FLAG_V] = 1'b1;
      end
      default: f = 4'b0000;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/cmpu_int_order.sv
module cmpu_int_order
  import cmpu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              is_signed,
  output rel_e              rel
);

  logic lt_s, lt_u, same;

  always_comb begin
    lt_s = $signed(a) < $signed(b);
    lt_u = a < b;
    same = (a == b);
    if (same)
      rel = REL_EQ;
    else if (is_signed ? lt_s : lt_u)
      rel = REL_LT;
    else
      rel = REL_GT;
  end

endmodule

// File: rtl/cmpu_fp_order.sv
module cmpu_fp_order
  import cmpu_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] a,
  input  logic [EXP_W+FRAC_W:0] b,
  output rel_e                  rel
);

  localparam int MAG_W = EXP_W + FRAC_W;

  logic             sa, sb;
  logic [MAG_W-1:0] ma, mb;
  logic             nan_a, nan_b, zero_both, mag_lt, mag_eq;

  always_comb begin
    sa    = a[MAG_W];
    sb    = b[MAG_W];
    ma    = a[MAG_W-1:0];
    mb    = b[MAG_W-1:0];
    nan_a = (&a[MAG_W-1:FRAC_W]) && (|a[FRAC_W-1:0]);
    nan_b = (&b[MAG_W-1:FRAC_W]) && (|b[FRAC_W-1:0]);
    zero_both = (ma == '0) && (mb == '0);
    mag_lt = ma < mb;
    mag_eq = ma == mb;

    if (nan_a || nan_b)
      rel = REL_UN;
    else if (zero_both)
      rel = REL_EQ;
    else if (sa != sb)
      rel = sa ? REL_LT : REL_GT;
    else if (mag_eq)
      rel = REL_EQ;
    else if (mag_lt ^ sa)
      rel = REL_LT;
    else
      rel = REL_GT;
  end

endmodule

// File: rtl/cmpu_cond_eval.sv
module cmpu_cond_eval
  import cmpu_pkg::*;
(
  input  logic [3:0] nzcv,
  input  logic [3:0] sel,
  output logic       pass,
  output logic       bad
);

  logic n, z, v;

  always_comb begin
    n    = nzcv[FLAG_N];
    z    = nzcv[FLAG_Z];
    v    = nzcv[FLAG_V];
    pass = 1'b0;
    bad  = 1'b0;
    case (sel)
      CS_ZSET:  pass = z;
      CS_ZCLR:  pass = ~z;
      CS_GEQ:   pass = (n == v);
      CS_LESS:  pass = (n != v);
      CS_GRT:   pass = ~z && (n == v);
      CS_LEQ:   pass = z || (n != v);
      CS_ALW:   pass = 1'b1;
      CS_NEVER: pass = 1'b0;
      default:  bad  = 1'b1;
    endcase
  end

endmodule

// File: rtl/cmpu_top.sv
module cmpu_top
  import cmpu_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmp_valid,
  input  logic [1:0]                cmp_mode,
  input  logic [EXP_W+FRAC_W:0]     op_a,
  input  logic [EXP_W+FRAC_W:0]     op_b,
  output logic [1:0]                rel_code,
  output logic [3:0]                flags,
  input  logic [3:0]                cond_sel,
  output logic                      cond_pass,
  output logic                      cond_err
);

  localparam int DATA_W = 1 + EXP_W + FRAC_W;
  localparam int MAG_W  = EXP_W + FRAC_W;

  rel_e       int_rel, fp_rel, sel_rel;
  logic       fp_mode;
  logic [3:0] flags_q;

  cmpu_int_order #(.DATA_W(DATA_W)) u_int (
    .a         (op_a),
    .b         (op_b),
    .is_signed (cmp_mode == MODE_SINT),
    .rel       (int_rel)
  );

  cmpu_fp_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fp (
    .a   (op_a),
    .b   (op_b),
    .rel (fp_rel)
  );

  assign fp_mode  = cmp_mode[1];
  assign sel_rel  = fp_mode ? fp_rel : int_rel;
  assign rel_code = sel_rel;

  always_ff @(posedge clk) begin
    if (!rst_n)
      flags_q <= 4'b0000;
    else if (cmp_valid)
      flags_q <= rel_to_nzcv(sel_rel);
  end

  assign flags = flags_q;

  cmpu_cond_eval u_cond (
    .nzcv (flags_q),
    .sel  (cond_sel),
    .pass (cond_pass),
    .bad  (cond_err)
  );

  // R6: unordered only in float mode
  p_unord_fp_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fp_mode) |-> (rel_code != 2'b11));

  // R5: signed zeros compare equal
  p_zero_equal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_mode && op_a[MAG_W-1:0] == '0 && op_b[MAG_W-1:0] == '0) |-> (rel_code == 2'b00));

  // R7: flag register only ever holds one of the four legal patterns
  p_flags_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q == 4'b0100) || (flags_q == 4'b1000) ||
    (flags_q == 4'b1001) || (flags_q == 4'b0000));

  // R7: a strobe captures the relation seen at the edge
  p_flags_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> (flags_q[FLAG_Z] == ($past(rel_code) == 2'b00)));

  // R8: no strobe, no change
  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> $stable(flags_q));

  // R10: an undefined selector never passes
  p_bad_cond_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cond_err |-> !cond_pass);

  // R9: always/never selectors
  p_always_never_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 4'b1110 |-> cond_pass) and (cond_sel == 4'b1111 |-> !cond_pass));

endmodule

// File: tb/cmpu_top_test.sv
`timescale 1ns/1ps
module cmpu_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 1'b0;
  logic [1:0]  cmp_mode = 2'b00;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [1:0]  rel_code;
  logic [3:0]  flags;
  logic [3:0]  cond_sel = 4'b0000;
  logic        cond_pass;
  logic        cond_err;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_flags = 4'b0000;

  always #2.5 clk = ~clk;

  cmpu_top uut (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_mode(cmp_mode),
    .op_a(op_a), .op_b(op_b), .rel_code(rel_code), .flags(flags),
    .cond_sel(cond_sel), .cond_pass(cond_pass), .cond_err(cond_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (mode=%0b a=%08h b=%08h sel=%0b)",
               req, act, exp, cmp_mode, op_a, op_b, cond_sel);
    end
  endtask

  function automatic logic is_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  // sortable key: folds -0 onto +0, then maps sign-magnitude to monotone unsigned
  function automatic logic [31:0] fkey(input logic [31:0] x);
    logic [31:0] y;
    y = (x[30:0] == 0) ? 32'h0 : x;
    return y[31] ? ~y : (y | 32'h8000_0000);
  endfunction

  function automatic logic [1:0] ref_rel(input logic [1:0] m, input logic [31:0] a, input logic [31:0] b);
    if (m[1]) begin
      if (is_nan(a) || is_nan(b)) return 2'b11;
      if (fkey(a) == fkey(b)) return 2'b00;
      return (fkey(a) < fkey(b)) ? 2'b01 : 2'b10;
    end else if (m == 2'b00) begin
      if (a == b) return 2'b00;
      return ($signed(a) < $signed(b)) ? 2'b01 : 2'b10;
    end else begin
      if (a == b) return 2'b00;
      return (a < b) ? 2'b01 : 2'b10;
    end
  endfunction

  function automatic logic [3:0] ref_flags(input logic [1:0] r);
    case (r)
      2'b00: return 4'b0100;
      2'b01: return 4'b1000;
      2'b10: return 4'b1001;
      default: return 4'b0000;
    endcase
  endfunction

  // returns {err, pass}
  function automatic logic [1:0] ref_gate(input logic [3:0] s, input logic [3:0] f);
    logic n, z, v;
    n = f[3]; z = f[2]; v = f[0];
    case (s)
      4'b0000: return {1'b0, z};
      4'b0001: return {1'b0, !z};
      4'b1010: return {1'b0, n == v};
      4'b1011: return {1'b0, n != v};
      4'b1100: return {1'b0, !z && n == v};
      4'b1101: return {1'b0, z || n != v};
      4'b1110: return 2'b01;
      4'b1111: return 2'b00;
      default: return 2'b10;
    endcase
  endfunction

  function automatic string rel_req(input logic [1:0] m, input logic [31:0] a, input logic [31:0] b);
    if (!m[1]) return (m == 2'b00) ? "R1/R2 signed" : "R1/R3 unsigned";
    if (is_nan(a) || is_nan(b)) return "R6 nan";
    if (a[30:0] == 0 && b[30:0] == 0) return "R5 zeros";
    return "R4 float";
  endfunction

  task automatic sweep_conds();
    for (int s = 0; s < 16; s++) begin
      logic [1:0] g;
      cond_sel = s[3:0];
      #0.2;
      g = ref_gate(s[3:0], exp_flags);
      if (g[1]) chk("R10 undefined selector err", {31'b0, cond_err}, 32'd1);
      else      chk("R10 defined selector err", {31'b0, cond_err}, 32'd0);
      chk(g[1] ? "R10 undefined selector gate" : "R9 gate", {31'b0, cond_pass}, {31'b0, g[0]});
    end
  endtask

  task automatic do_cmp(input logic [1:0] m, input logic [31:0] a, input logic [31:0] b);
    logic [1:0] r;
    @(negedge clk);
    cmp_mode = m; op_a = a; op_b = b; cmp_valid = 1'b1;
    #1;
    r = ref_rel(m, a, b);
    chk(rel_req(m, a, b), {30'b0, rel_code}, {30'b0, r});
    if (!m[1] && r == 2'b11) chk("R6 int never unordered", 32'd1, 32'd0);
    @(negedge clk);
    cmp_valid = 1'b0;
    exp_flags = ref_flags(r);
    #0.5;
    chk("R7 flags load", {28'b0, flags}, {28'b0, exp_flags});
    sweep_conds();
  endtask

  task automatic hold_check(input logic [1:0] m, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cmp_mode = m; op_a = a; op_b = b; cmp_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    #0.5;
    chk("R8 flags hold without strobe", {28'b0, flags}, {28'b0, exp_flags});
  endtask

  function automatic logic [31:0] rnd_fp();
    logic [31:0] x;
    x = $urandom;
    case ($urandom % 8)
      0: x = {x[31], 8'hFF, (x[22:0] == 0) ? 23'h1 : x[22:0]};
      1: x = {x[31], 31'h0};
      2: x = {x[31], 8'hFF, 23'h0};
      3: x = {x[31], 8'h7F, x[22:20], 20'h0};
      default: ;
    endcase
    return x;
  endfunction

  function automatic logic [31:0] rnd_int();
    case ($urandom % 6)
      0: return 32'h8000_0000;
      1: return 32'h7FFF_FFFF;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    logic [1:0]  m;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    chk("R8 reset flags", {28'b0, flags}, 32'd0);
    exp_flags = 4'b0000;
    sweep_conds();

    // integer corners
    do_cmp(2'b00, 32'h8000_0000, 32'h7FFF_FFFF);   // R2 min < max
    do_cmp(2'b01, 32'h8000_0000, 32'h7FFF_FFFF);   // R3 unsigned greater
    do_cmp(2'b00, 32'hFFFF_FFFF, 32'h0000_0001);   // R2 -1 < 1
    do_cmp(2'b01, 32'h1234_5678, 32'h1234_5678);   // R3 equal
    hold_check(2'b01, 32'h0, 32'h5);               // R8
    do_cmp(2'b01, 32'h0000_0000, 32'hFFFF_FFFF);   // R3 less
    // float corners
    do_cmp(2'b10, 32'h8000_0000, 32'h0000_0000);   // R5 -0 == +0
    do_cmp(2'b11, 32'h0000_0000, 32'h8000_0000);   // R5
    do_cmp(2'b10, 32'h8000_0000, 32'h8000_0000);   // R5
    do_cmp(2'b10, 32'h7FC0_0000, 32'h3F80_0000);   // R6 NaN a
    hold_check(2'b00, 32'h1, 32'h2);               // R8 unordered flags held
    do_cmp(2'b10, 32'h3F80_0000, 32'h7F80_0001);   // R6 NaN b
    do_cmp(2'b10, 32'hBF80_0000, 32'hC000_0000);   // R4 -1 > -2
    do_cmp(2'b10, 32'hFF80_0000, 32'h7F80_0000);   // R4 -inf < +inf
    do_cmp(2'b10, 32'h3F80_0000, 32'h4000_0000);   // R4 1 < 2
    do_cmp(2'b10, 32'h0000_0001, 32'h8000_0001);   // R4 tiny +/-
    do_cmp(2'b00, 32'h7FC0_0000, 32'h7FC0_0000);   // R6 NaN pattern equal in int mode

    for (int i = 0; i < 400; i++) begin
      m = 2'($urandom % 4);
      if (m[1]) begin a = rnd_fp(); b = ($urandom % 6 == 0) ? a : rnd_fp(); end
      else      begin a = rnd_int(); b = ($urandom % 6 == 0) ? a : rnd_int(); end
      do_cmp(m, a, b);
      if (i % 25 == 0) hold_check(2'($urandom % 4), $urandom, $urandom);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule